// File: doc/BRIEF.md
# TDM Receive Slot and Error Tracker

This block follows the receive side of a time-division-multiplexed serial audio link. It sees one strobe for each received serial bit, plus a frame-sync marker that comes with the first bit of a frame. From these it keeps a running count of the current time slot. Frame length in slots and slot width in bits come from two configuration inputs. The last bit of every slot counts as a word transfer into the receive buffer.

Two sticky error flags watch the stream:
- An early-sync flag catches a frame sync that arrives while a frame is still in progress.
- An overrun flag catches a word transfer into a buffer whose previous word was never read.

Software clears each flag by writing 1 to it. Each flag has its own enable bit, and the enabled flags combine into one interrupt output. A small register port gives read access to the flags, the enables and the slot count, and write access to the flags and enables.

The slot count is 9 bits wide. Normal frames are short (up to 32 slots), but the counter can reach 383 for block-style transfers that run as one long frame.

Top module: `tdm_rx_tracker`

## Requirements
- R1: With N = min(cfg_len_m1, 383) + 1 slots per frame and W = cfg_bits_m1 + 1 bits per slot, the slot count after j valid bits since the last accepted frame sync equals floor(j / W) mod N. Before the first frame sync the count stays 0.
- R2: Frame sync and all counting act only on cycles where bit_valid is 1. A frame sync without bit_valid leaves the count and the flags unchanged.
- R3: A frame sync with bit_valid that arrives when the tracker is not at slot 0, bit 0 of a frame already under way sets the early-sync flag (status bit 1). The frame then restarts from that bit. A frame sync exactly at the frame boundary sets nothing.
- R4: The last bit of each slot is a word transfer, which marks the buffer full; buf_rd marks it empty. A transfer while the buffer is full and no buf_rd is present in the same cycle sets the overrun flag (status bit 0).
- R5: Writing 1 to a status bit (address 0) clears that flag. Writing 0 leaves it unchanged.
- R6: If a flag's set event and a write-1 clear of that flag fall in the same cycle, the flag ends up set.
- R7: irq is 1 exactly when some status bit and the enable bit at the same position (address 1, bits 1:0) are both 1.
- R8: Address 2 reads the slot count in bits 8:0, with bits 31:9 reading 0. Writes to address 2 have no effect. The count reaches 383 when N is 384, and length codes above 383 act as 383. Address 3 reads 0.
- R9: After reset the flags, the enables and the slot count are 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid | input | 1 | One received serial bit this cycle |
| fsync | input | 1 | Frame-sync marker, taken with bit_valid |
| cfg_len_m1 | input | 9 | Slots per frame minus one |
| cfg_bits_m1 | input | 5 | Bits per slot minus one |
| buf_rd | input | 1 | Receive buffer is read this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Combined receive error interrupt |

## Verification
The assertions assume that the configuration inputs stay constant while a frame is in progress. A mid-frame change would break the link between frame sync and slot position that the restart property relies on. They also assume that bit_valid, fsync and buf_rd are clean single-cycle qualifiers sampled at the clock edge.

The stimulus changes the configuration only at frame boundaries or right after a reset. It drives all inputs half a cycle away from the sampling edge. Each sweep is built from whole frames, so the only early syncs are the ones the early-sync tests inject on purpose.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int SLOT_W      = 9;
  localparam int SLOT_MAX    = 383;
  localparam int BITC_W      = 5;
  localparam int REG_W       = 32;
  localparam int ADDR_W      = 2;
  localparam int NUM_FLAGS   = 2;
  localparam int FLAG_OVR    = 0;
  localparam int FLAG_EARLY  = 1;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 2'd0,
    A_ENABLE = 2'd1,
    A_SLOT   = 2'd2,
    A_SPARE  = 2'd3
  } reg_addr_e;

  // Highest slot index of a frame, capped at the counter's legal maximum.
  function automatic logic [SLOT_W-1:0] cap_last_slot(input logic [SLOT_W-1:0] len_m1);
    return (len_m1 > SLOT_W'(SLOT_MAX)) ? SLOT_W'(SLOT_MAX) : len_m1;
  endfunction

  // Slot index that follows a given one, wrapping after the last slot.
  function automatic logic [SLOT_W-1:0] step_slot(input logic [SLOT_W-1:0] cur,
                                                  input logic [SLOT_W-1:0] last);
    return (cur >= last) ? '0 : cur + 1'b1;
  endfunction
endpackage

// File: rtl/tdm_slot_tracker.sv
module tdm_slot_tracker
  import tdm_rx_pkg::*;
#(
  parameter int SW = SLOT_W,
  parameter int BW = BITC_W
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_valid,
  input  logic          fsync,
  input  logic [SW-1:0] last_slot,
  input  logic [BW-1:0] last_bit,
  output logic [SW-1:0] slot_cnt,
  output logic          xfer,
  output logic          early_evt
);
  logic [SW-1:0] slot_q;
  logic [BW-1:0] bit_q;
  logic          in_frame_q;
  logic          frame_start;
  logic          active;
  logic [SW-1:0] cur_slot;
  logic [BW-1:0] cur_bit;
  logic          slot_end;

  assign frame_start = bit_valid & fsync;
  assign active      = frame_start | in_frame_q;
  assign cur_slot    = frame_start ? '0 : slot_q;
  assign cur_bit     = frame_start ? '0 : bit_q;
  assign slot_end    = (cur_bit >= last_bit);
  assign xfer        = bit_valid & active & slot_end;
  assign early_evt   = frame_start & in_frame_q & ((slot_q != '0) | (bit_q != '0));
  assign slot_cnt    = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q     <= '0;
      bit_q      <= '0;
      in_frame_q <= 1'b0;
    end else if (bit_valid && active) begin
      in_frame_q <= 1'b1;
      if (slot_end) begin
        bit_q  <= '0;
        slot_q <= step_slot(cur_slot, last_slot);
      end else begin
        bit_q  <= cur_bit + 1'b1;
        slot_q <= cur_slot;
      end
    end
  end
endmodule

// File: rtl/tdm_buf_monitor.sv
module tdm_buf_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer,
  input  logic buf_rd,
  output logic ovr_evt
);
  logic full_q;

  assign ovr_evt = xfer & full_q & ~buf_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= xfer | (full_q & ~buf_rd);
  end
endmodule

// File: rtl/tdm_flag_bank.sv
module tdm_flag_bank #(
  parameter int NF = 2
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_evt,
  input  logic [NF-1:0] clr_req,
  output logic [NF-1:0] flags
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f_q <= 1'b0;
      else        f_q <= set_evt[i] | (f_q & ~clr_req[i]);
    end
    assign flags[i] = f_q;
  end
endmodule

// File: rtl/tdm_rx_tracker.sv
module tdm_rx_tracker
  import tdm_rx_pkg::*;
#(
  parameter int SW = SLOT_W,
  parameter int BW = BITC_W,
  parameter int DW = REG_W,
  parameter int AW = ADDR_W,
  parameter int NF = NUM_FLAGS
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_valid,
  input  logic          fsync,
  input  logic [SW-1:0] cfg_len_m1,
  input  logic [BW-1:0] cfg_bits_m1,
  input  logic          buf_rd,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  logic [SW-1:0] last_slot;
  logic [SW-1:0] slot_cnt;
  logic          xfer;
  logic          early_evt;
  logic          ovr_evt;
  logic [NF-1:0] set_evt;
  logic [NF-1:0] clr_req;
  logic [NF-1:0] flags;
  logic [NF-1:0] en_q;

  assign last_slot = cap_last_slot(cfg_len_m1);

  tdm_slot_tracker #(.SW(SW), .BW(BW)) u_slot (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .fsync(fsync),
    .last_slot(last_slot), .last_bit(cfg_bits_m1),
    .slot_cnt(slot_cnt), .xfer(xfer), .early_evt(early_evt)
  );

  tdm_buf_monitor u_buf (
    .clk(clk), .rst_n(rst_n), .xfer(xfer), .buf_rd(buf_rd), .ovr_evt(ovr_evt)
  );

  always_comb begin
    set_evt             = '0;
    set_evt[FLAG_OVR]   = ovr_evt;
    set_evt[FLAG_EARLY] = early_evt;
  end

  assign clr_req = (wr_en && wr_addr == AW'(A_STATUS)) ? wr_data[NF-1:0] : '0;

  tdm_flag_bank #(.NF(NF)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_req(clr_req), .flags(flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  en_q <= '0;
    else if (wr_en && wr_addr == AW'(A_ENABLE))  en_q <= wr_data[NF-1:0];
  end

  assign irq = |(flags & en_q);

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      AW'(A_STATUS): rd_data[NF-1:0] = flags;
      AW'(A_ENABLE): rd_data[NF-1:0] = en_q;
      AW'(A_SLOT):   rd_data[SW-1:0] = slot_cnt;
      default:       rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tdm_rx_tracker_chk.sv
module tdm_rx_tracker_chk #(
  parameter int SW = 9,
  parameter int BW = 5,
  parameter int DW = 32,
  parameter int AW = 2,
  parameter int NF = 2
)(
  input logic          clk,
  input logic          rst_n,
  input logic          bit_valid,
  input logic          fsync,
  input logic [BW-1:0] cfg_bits_m1,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [SW-1:0] slot_cnt,
  input logic [NF-1:0] flags,
  input logic [NF-1:0] en_q,
  input logic          irq,
  input logic          early_evt,
  input logic          ovr_evt
);
  // R8
  slot_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_cnt <= SW'(383));

  // R2
  idle_holds_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(slot_cnt));

  // R3
  restart_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && fsync && cfg_bits_m1 != '0) |=> slot_cnt == '0);

  // R3
  early_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    early_evt |=> flags[1]);

  // R4
  ovr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> flags[0]);

  // R5
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0 && wr_data[0] && !ovr_evt) |=> !flags[0]);

  // R5
  w0_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0 && !wr_data[1] && flags[1]) |=> flags[1]);

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && wr_en && wr_addr == '0 && wr_data[0]) |=> flags[0]);

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0 && en_q != '0));
endmodule

bind tdm_rx_tracker tdm_rx_tracker_chk #(.SW(SW), .BW(BW), .DW(DW), .AW(AW), .NF(NF)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .fsync(fsync),
  .cfg_bits_m1(cfg_bits_m1), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .slot_cnt(slot_cnt), .flags(flags), .en_q(en_q), .irq(irq),
  .early_evt(early_evt), .ovr_evt(ovr_evt)
);

// File: tb/tdm_rx_tracker_tb.sv
module tdm_rx_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_valid = 1'b0;
  logic        fsync = 1'b0;
  logic [8:0]  cfg_len_m1 = '0;
  logic [4:0]  cfg_bits_m1 = '0;
  logic        buf_rd = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  tdm_rx_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .fsync(fsync),
    .cfg_len_m1(cfg_len_m1), .cfg_bits_m1(cfg_bits_m1), .buf_rd(buf_rd),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic cyc(input logic v, input logic fs, input logic rdb,
                     input logic we, input logic [1:0] wa, input logic [31:0] wd);
    bit_valid = v; fsync = fs; buf_rd = rdb;
    wr_en = we; wr_addr = wa; wr_data = wd;
    @(negedge clk);
    bit_valid = 1'b0; fsync = 1'b0; buf_rd = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic wr(input logic [1:0] wa, input logic [31:0] wd);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, wa, wd);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();

    // R9 reset state
    rd(2'd0, d); chk("R9 status", d, 0);
    rd(2'd1, d); chk("R9 enable", d, 0);
    rd(2'd2, d); chk("R9 slot", d, 0);
    chk("R9 irq", {31'b0, irq}, 0);

    // R1 before any sync the count stays 0
    cyc(1, 0, 1, 0, 0, 0);
    cyc(1, 0, 1, 0, 0, 0);
    rd(2'd2, d); chk("R1 no sync yet", d, 0);

    // R1 sweep over small frame shapes, whole frames only
    for (int lm = 0; lm < 4; lm++) begin
      for (int bm = 0; bm < 3; bm++) begin
        int nw;
        cfg_len_m1 = 9'(lm);
        cfg_bits_m1 = 5'(bm);
        nw = (lm + 1) * (bm + 1);
        for (int i = 0; i < 2 * nw; i++) begin
          cyc(1, (i % nw) == 0, 1, 0, 0, 0);
          rd(2'd2, d);
          chk("R1 slot sweep", d, 32'((((i % nw) + 1) / (bm + 1)) % (lm + 1)));
        end
      end
    end
    rd(2'd0, d); chk("R3 boundary sync sets nothing", d, 0);

    // R3 early sync
    do_reset();
    cfg_len_m1 = 9'd3; cfg_bits_m1 = 5'd1;
    cyc(1, 1, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 0, 0, 0);
    rd(2'd0, d); chk("R3 no flag mid frame", d, 0);
    cyc(1, 1, 1, 0, 0, 0);
    rd(2'd0, d); chk("R3 early flag", d, 2);
    rd(2'd2, d); chk("R3 restart slot", d, 0);
    chk("R7 irq off when disabled", {31'b0, irq}, 0);
    wr(2'd1, 32'h2);
    chk("R7 irq on early", {31'b0, irq}, 1);
    wr(2'd0, 32'h0);
    rd(2'd0, d); chk("R5 write 0 keeps", d, 2);
    wr(2'd0, 32'h1);
    rd(2'd0, d); chk("R5 other bit keeps", d, 2);
    wr(2'd0, 32'h2);
    rd(2'd0, d); chk("R5 write 1 clears", d, 0);
    chk("R7 irq drops", {31'b0, irq}, 0);

    // R2 sync without bit_valid ignored (1 bit into frame now)
    cyc(0, 1, 1, 0, 0, 0);
    rd(2'd0, d); chk("R2 no early flag", d, 0);
    rd(2'd2, d); chk("R2 slot unchanged", d, 0);
    cyc(1, 0, 1, 0, 0, 0);
    rd(2'd2, d); chk("R2 counting continues", d, 1);

    // R4 overrun, one bit per slot
    do_reset();
    cfg_len_m1 = 9'd3; cfg_bits_m1 = 5'd0;
    cyc(1, 1, 0, 0, 0, 0);
    rd(2'd0, d); chk("R4 first word no overrun", d, 0);
    cyc(1, 0, 0, 0, 0, 0);
    rd(2'd0, d); chk("R4 overrun set", d, 1);
    chk("R7 irq off, enable 0", {31'b0, irq}, 0);
    wr(2'd1, 32'h1);
    chk("R7 irq on overrun", {31'b0, irq}, 1);
    wr(2'd0, 32'h1);
    rd(2'd0, d); chk("R5 overrun cleared", d, 0);
    cyc(1, 0, 1, 0, 0, 0);
    rd(2'd0, d); chk("R4 read same cycle", d, 0);
    cyc(0, 0, 1, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    rd(2'd0, d); chk("R4 read before transfer", d, 0);
    cyc(1, 0, 0, 1, 2'd0, 32'h1);
    rd(2'd0, d); chk("R6 set beats clear", d, 1);

    // R8 long frame to 383 and register port
    do_reset();
    cfg_len_m1 = 9'd383; cfg_bits_m1 = 5'd0;
    cyc(1, 1, 1, 0, 0, 0);
    for (int i = 0; i < 382; i++) cyc(1, 0, 1, 0, 0, 0);
    rd(2'd2, d); chk("R8 reaches 383", d, 383);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R8 write ignored, upper zero", d, 383);
    rd(2'd3, d); chk("R8 spare reads zero", d, 0);
    cyc(1, 0, 1, 0, 0, 0);
    rd(2'd2, d); chk("R8 wrap after 383", d, 0);

    // R8 length code above 383 caps
    do_reset();
    cfg_len_m1 = 9'd511;
    cyc(1, 1, 1, 0, 0, 0);
    for (int i = 0; i < 382; i++) cyc(1, 0, 1, 0, 0, 0);
    rd(2'd2, d); chk("R8 capped 383", d, 383);
    cyc(1, 0, 1, 0, 0, 0);
    rd(2'd2, d); chk("R8 capped wrap", d, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule